// File: doc/BRIEF.md
# Asynchronous static RAM access controller

This block sits between an on-chip master and an external 64K-word by 16-bit asynchronous static RAM. The master presents one request at a time over a valid/ready handshake: a word address, write data, a read/write flag and a two-bit lane mask. The controller turns each request into a correctly timed sequence on the memory pins and, for a read, returns the merged word with a one-cycle strobe.

All pin timing comes from nanosecond limits given as parameters, each rounded up to whole clock cycles for the configured clock period. A read holds chip select and output enable low for the read-cycle count, and the data on the bus is captured on the last of those cycles. A write opens with one or more setup cycles in which chip select and the data drivers are active but write enable is still high, then holds write enable low for the pulse count. After any read, writes are held off for a turnaround window so the memory has released the bus before the controller drives it.

The data bus is brought out as a separate output value, output enable and input value, so that the bidirectional pad sits in the pad ring.

Top module: `asram_ctl`

## Requirements
- R1: Out of reset and whenever no access is in progress, chip select, output enable, write enable and both byte enables are high, the data drivers are off and `req_ready` is high; asserting `rst_n` low forces this state at once, even mid-access.
- R2: A read holds `mem_cs_n` and `mem_oe_n` low and `mem_we_n` high for RD = ceil(T_RC_NS/CLK_NS) consecutive cycles starting the cycle after acceptance, with `mem_addr` equal to the request address throughout.
- R3: Read data is sampled on the last cycle that output enable is low; `rsp_valid` is high for exactly one cycle, the cycle after that, carrying the sampled word.
- R4: Mask bit 0 selects the lower lane (data bits 7:0, `mem_lb_n`) and mask bit 1 the upper lane (bits 15:8, `mem_ub_n`); a lane's enable pin is low through the whole access exactly when its mask bit is 1, and on a read a lane whose mask bit is 0 is returned as zero.
- R5: A write holds `mem_cs_n` low for WR = max(ceil(T_WC_NS/CLK_NS), WP+1) cycles, keeps `mem_oe_n` high, keeps `mem_we_n` high in its first cycle and then low for WP = ceil(T_WP_NS/CLK_NS) cycles, ending together with chip select.
- R6: Address and byte enables do not change while write enable is low.
- R7: After a read ends, a write request is not accepted for TA = max(1, ceil(T_HZ_NS/CLK_NS)) cycles; a read request is accepted immediately.
- R8: A request is taken on a clock edge where `req_valid` and `req_ready` are both high; `req_ready` is low while chip select is low.
- R9: A request with mask 00 runs its full cycle with both byte enables high: a write changes no memory word and a read returns zero.
- R10: `mem_dq_oe` is high only while a write holds chip select low, and `mem_dq_out` then equals the request's write data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request taken this cycle if valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Lane mask, bit 1 upper, bit 0 lower |
| rsp_valid | output | 1 | One-cycle read-data strobe |
| rsp_rdata | output | 16 | Read word, unselected lanes zero |
| mem_addr | output | AW | Memory address pins |
| mem_dq_out | output | 16 | Value to drive on the data pins |
| mem_dq_oe | output | 1 | Data pad driver enable |
| mem_dq_in | input | 16 | Value seen on the data pins |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_ub_n | output | 1 | Upper lane enable, active low |
| mem_lb_n | output | 1 | Lower lane enable, active low |

## Verification
The properties assume the master holds request fields steady while `req_valid` waits for `req_ready`, and that the pad model returns a settled value on `mem_dq_in` by the last read cycle. The bench drives each request at a falling edge, keeps it until it is taken, and lets its memory model answer combinationally from the pins, with a fixed filler value on any lane that is floating so that the zeroing of unselected lanes is visible. The timing checks assume the clock period parameter matches the real clock, so the bench sets it to the bench period and derives all expected cycle counts from the nanosecond limits.

// File: rtl/asram_pkg.sv
package asram_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_READ,
    ST_WSETUP,
    ST_WPULSE
  } asram_st_e;

  // Whole clock cycles needed to cover a limit in nanoseconds.
  function automatic int ns2cyc(input int lim_ns, input int clk_ns);
    return (lim_ns + clk_ns - 1) / clk_ns;
  endfunction

endpackage

// File: rtl/asram_rst_sync.sv
module asram_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign srst_n = sync_q;

endmodule

// File: rtl/asram_rdcap.sv
module asram_rdcap #(
  parameter int NLANE = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cap_en,
  input  logic [NLANE-1:0]   lane_en,
  input  logic [8*NLANE-1:0] din,
  output logic [8*NLANE-1:0] rdata,
  output logic               rvalid
);

  logic [8*NLANE-1:0] merged;
  logic [8*NLANE-1:0] rdata_q;
  logic               rvalid_q;

  for (genvar l = 0; l < NLANE; l++) begin : g_lane
    assign merged[l*8 +: 8] = lane_en[l] ? din[l*8 +: 8] : 8'h00;
  end

  // Data register: clock enable only, no reset needed.
  always_ff @(posedge clk) begin
    if (cap_en) begin
      rdata_q <= merged;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= cap_en;
    end
  end

  assign rdata  = rdata_q;
  assign rvalid = rvalid_q;

endmodule

// File: rtl/asram_ctl.sv
module asram_ctl
  import asram_pkg::*;
#(
  parameter int AW      = 16,
  parameter int CLK_NS  = 10,
  parameter int T_RC_NS = 70,
  parameter int T_WC_NS = 70,
  parameter int T_WP_NS = 55,
  parameter int T_HZ_NS = 25
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [15:0]   req_wdata,
  input  logic [1:0]    req_mask,
  output logic          rsp_valid,
  output logic [15:0]   rsp_rdata,
  output logic [AW-1:0] mem_addr,
  output logic [15:0]   mem_dq_out,
  output logic          mem_dq_oe,
  input  logic [15:0]   mem_dq_in,
  output logic          mem_cs_n,
  output logic          mem_oe_n,
  output logic          mem_we_n,
  output logic          mem_ub_n,
  output logic          mem_lb_n
);

  localparam int RD_CYC = ns2cyc(T_RC_NS, CLK_NS);
  localparam int WP_CYC = ns2cyc(T_WP_NS, CLK_NS);
  localparam int WC_RAW = ns2cyc(T_WC_NS, CLK_NS);
  localparam int WR_CYC = (WC_RAW > WP_CYC) ? WC_RAW : WP_CYC + 1;
  localparam int SU_CYC = WR_CYC - WP_CYC;
  localparam int HZ_RAW = ns2cyc(T_HZ_NS, CLK_NS);
  localparam int TA_CYC = (HZ_RAW > 1) ? HZ_RAW : 1;
  localparam int CMAX   = (RD_CYC > WR_CYC) ? RD_CYC : WR_CYC;
  localparam int CW     = $clog2(CMAX + 1);
  localparam int TW     = $clog2(TA_CYC + 1);

  logic rst_s_n;

  asram_rst_sync u_rst_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_s_n)
  );

  // Control state
  asram_st_e     st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [TW-1:0] ta_q, ta_d;
  logic          cs_q, cs_d, oe_q, oe_d, we_q, we_d;
  logic          ub_q, ub_d, lb_q, lb_d, dqe_q, dqe_d;
  // Datapath registers (loaded on acceptance)
  logic [AW-1:0] addr_q;
  logic [15:0]   wdat_q;
  logic [1:0]    mask_q;

  logic accept;
  logic cap_en;

  assign req_ready = (st_q == ST_IDLE) && !(req_write && (ta_q != '0));
  assign accept    = req_valid && req_ready;
  assign cap_en    = (st_q == ST_READ) && (cnt_q == '0);

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    ta_d  = (ta_q != '0) ? ta_q - 1'b1 : ta_q;
    cs_d  = cs_q;
    oe_d  = oe_q;
    we_d  = we_q;
    ub_d  = ub_q;
    lb_d  = lb_q;
    dqe_d = dqe_q;
    case (st_q)
      ST_IDLE: begin
        if (accept) begin
          cs_d = 1'b0;
          ub_d = ~req_mask[1];
          lb_d = ~req_mask[0];
          if (req_write) begin
            dqe_d = 1'b1;
            cnt_d = CW'(SU_CYC - 1);
            st_d  = ST_WSETUP;
          end else begin
            oe_d  = 1'b0;
            cnt_d = CW'(RD_CYC - 1);
            st_d  = ST_READ;
          end
        end
      end
      ST_READ: begin
        if (cnt_q == '0) begin
          cs_d = 1'b1;
          oe_d = 1'b1;
          ub_d = 1'b1;
          lb_d = 1'b1;
          ta_d = TW'(TA_CYC);
          st_d = ST_IDLE;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_WSETUP: begin
        if (cnt_q == '0) begin
          we_d  = 1'b0;
          cnt_d = CW'(WP_CYC - 1);
          st_d  = ST_WPULSE;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_WPULSE: begin
        if (cnt_q == '0) begin
          we_d  = 1'b1;
          cs_d  = 1'b1;
          ub_d  = 1'b1;
          lb_d  = 1'b1;
          dqe_d = 1'b0;
          st_d  = ST_IDLE;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      ta_q  <= '0;
      cs_q  <= 1'b1;
      oe_q  <= 1'b1;
      we_q  <= 1'b1;
      ub_q  <= 1'b1;
      lb_q  <= 1'b1;
      dqe_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      ta_q  <= ta_d;
      cs_q  <= cs_d;
      oe_q  <= oe_d;
      we_q  <= we_d;
      ub_q  <= ub_d;
      lb_q  <= lb_d;
      dqe_q <= dqe_d;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      addr_q <= req_addr;
      wdat_q <= req_wdata;
      mask_q <= req_mask;
    end
  end

  asram_rdcap #(
    .NLANE (2)
  ) u_rdcap (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .cap_en  (cap_en),
    .lane_en (mask_q),
    .din     (mem_dq_in),
    .rdata   (rsp_rdata),
    .rvalid  (rsp_valid)
  );

  assign mem_addr   = addr_q;
  assign mem_dq_out = wdat_q;
  assign mem_dq_oe  = dqe_q;
  assign mem_cs_n   = cs_q;
  assign mem_oe_n   = oe_q;
  assign mem_we_n   = we_q;
  assign mem_ub_n   = ub_q;
  assign mem_lb_n   = lb_q;

endmodule

// File: rtl/asram_ctl_chk.sv
module asram_ctl_chk
  import asram_pkg::*;
#(
  parameter int AW      = 16,
  parameter int CLK_NS  = 10,
  parameter int T_WP_NS = 55,
  parameter int T_HZ_NS = 25
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic          rsp_valid,
  input logic [AW-1:0] mem_addr,
  input logic          mem_cs_n,
  input logic          mem_oe_n,
  input logic          mem_we_n,
  input logic          mem_ub_n,
  input logic          mem_lb_n,
  input logic          mem_dq_oe
);

  localparam int WP_CYC = ns2cyc(T_WP_NS, CLK_NS);
  localparam int HZ_RAW = ns2cyc(T_HZ_NS, CLK_NS);
  localparam int TA_CYC = (HZ_RAW > 1) ? HZ_RAW : 1;

  logic [7:0] we_len_q;
  logic [7:0] since_rd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_len_q   <= 8'd0;
      since_rd_q <= 8'hff;
    end else begin
      if (mem_we_n) begin
        we_len_q <= 8'd0;
      end else if (we_len_q != 8'hff) begin
        we_len_q <= we_len_q + 8'd1;
      end
      if (!mem_oe_n) begin
        since_rd_q <= 8'd0;
      end else if (since_rd_q != 8'hff) begin
        since_rd_q <= since_rd_q + 8'd1;
      end
    end
  end

  AST_OE_WE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_oe_n && !mem_we_n)); // R5

  AST_WE_PULSE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (int'(we_len_q) == WP_CYC)); // R5

  AST_WE_AFTER_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we_n) |-> (!mem_cs_n && !$past(mem_cs_n))); // R5

  AST_PINS_STABLE_IN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n && !$past(mem_we_n)) |->
      ($stable(mem_addr) && $stable(mem_ub_n) && $stable(mem_lb_n))); // R6

  AST_TURNAROUND: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_dq_oe) |-> (int'(since_rd_q) >= TA_CYC)); // R7

  AST_READY_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> mem_cs_n); // R8

  AST_DRIVE_ONLY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> (!mem_cs_n && mem_oe_n)); // R10

  AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R3

endmodule

bind asram_ctl asram_ctl_chk #(
  .AW      (AW),
  .CLK_NS  (CLK_NS),
  .T_WP_NS (T_WP_NS),
  .T_HZ_NS (T_HZ_NS)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .mem_addr  (mem_addr),
  .mem_cs_n  (mem_cs_n),
  .mem_oe_n  (mem_oe_n),
  .mem_we_n  (mem_we_n),
  .mem_ub_n  (mem_ub_n),
  .mem_lb_n  (mem_lb_n),
  .mem_dq_oe (mem_dq_oe)
);

// File: tb/test_asram_ctl.sv
module test_asram_ctl;

  localparam int CLKP = 8;
  // Expected counts, from the nanosecond limits at an 8 ns clock
  localparam int RD_E = (70 + CLKP - 1) / CLKP;            // 9
  localparam int WP_E = (55 + CLKP - 1) / CLKP;            // 7
  localparam int WR_E = (RD_E > WP_E) ? RD_E : WP_E + 1;   // 9 (T_WC = 70)
  localparam int TA_E = (25 + CLKP - 1) / CLKP;            // 4
  localparam int WIN  = 16;

  typedef struct packed {
    logic        wr;
    logic [15:0] a;
    logic [15:0] d;
    logic [1:0]  m;
  } vec_t;

  localparam vec_t VECS [12] = '{
    '{1'b1, 16'h0010, 16'h1234, 2'b11},
    '{1'b1, 16'h0021, 16'hABCD, 2'b11},
    '{1'b0, 16'h0010, 16'h0000, 2'b11},
    '{1'b1, 16'h0010, 16'hFF00, 2'b10},
    '{1'b0, 16'h0010, 16'h0000, 2'b11},
    '{1'b0, 16'h0010, 16'h0000, 2'b01},
    '{1'b0, 16'h0021, 16'h0000, 2'b10},
    '{1'b1, 16'h0021, 16'h0077, 2'b01},
    '{1'b0, 16'h0021, 16'h0000, 2'b11},
    '{1'b1, 16'h0010, 16'h5555, 2'b00},
    '{1'b0, 16'h0010, 16'h0000, 2'b11},
    '{1'b0, 16'h0010, 16'h0000, 2'b00}
  };

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic        req_write;
  logic [15:0] req_addr;
  logic [15:0] req_wdata;
  logic [1:0]  req_mask;
  logic        rsp_valid;
  logic [15:0] rsp_rdata;
  logic [15:0] mem_addr;
  logic [15:0] mem_dq_out;
  logic        mem_dq_oe;
  logic [15:0] mem_dq_in;
  logic        mem_cs_n, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n;

  int n_chk;
  int n_fail;

  asram_ctl #(
    .CLK_NS (CLKP)
  ) i_asram_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .req_mask   (req_mask),
    .rsp_valid  (rsp_valid),
    .rsp_rdata  (rsp_rdata),
    .mem_addr   (mem_addr),
    .mem_dq_out (mem_dq_out),
    .mem_dq_oe  (mem_dq_oe),
    .mem_dq_in  (mem_dq_in),
    .mem_cs_n   (mem_cs_n),
    .mem_oe_n   (mem_oe_n),
    .mem_we_n   (mem_we_n),
    .mem_ub_n   (mem_ub_n),
    .mem_lb_n   (mem_lb_n)
  );

  initial clk = 1'b0;
  always #(CLKP / 2) clk = ~clk;

  // Behavioural memory on the low 8 address bits; floating lanes read 8'hA5.
  logic [15:0] sram   [256];
  logic [15:0] shadow [256];

  always_comb begin
    mem_dq_in = 16'hA5A5;
    if (!mem_cs_n && !mem_oe_n && mem_we_n) begin
      if (!mem_lb_n) mem_dq_in[7:0]  = sram[mem_addr[7:0]][7:0];
      if (!mem_ub_n) mem_dq_in[15:8] = sram[mem_addr[7:0]][15:8];
    end
  end

  always @(posedge clk) begin
    if (!mem_cs_n && !mem_we_n && mem_dq_oe) begin
      if (!mem_lb_n) sram[mem_addr[7:0]][7:0]  <= mem_dq_out[7:0];
      if (!mem_ub_n) sram[mem_addr[7:0]][15:8] <= mem_dq_out[15:8];
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog expired (R1..R10 run incomplete) actual=1 expected=0");
    report();
    $finish;
  end

  // Per-access observations
  int o_cs, o_oe, o_we, o_dqe, o_bad, o_rdy, o_rsp, o_rsp_at;
  logic o_we_first;
  logic [15:0] o_rd;

  task automatic run_op(input vec_t v);
    int g;
    @(negedge clk);
    req_valid = 1'b1;
    req_write = v.wr;
    req_addr  = v.a;
    req_wdata = v.d;
    req_mask  = v.m;
    g = 0;
    while (!req_ready && g < 50) begin
      @(negedge clk);
      g++;
    end
    @(negedge clk);
    req_valid = 1'b0;
    o_cs = 0; o_oe = 0; o_we = 0; o_dqe = 0; o_bad = 0; o_rdy = 0;
    o_rsp = 0; o_rsp_at = 0; o_rd = 16'h0; o_we_first = 1'b0;
    for (int k = 1; k <= WIN; k++) begin
      if (k > 1) @(negedge clk);
      if (k == 1) o_we_first = mem_we_n;
      if (!mem_cs_n) begin
        o_cs++;
        if (mem_addr != v.a || mem_ub_n != ~v.m[1] || mem_lb_n != ~v.m[0]) o_bad++;
        if (req_ready) o_rdy++;
      end
      if (!mem_oe_n) o_oe++;
      if (!mem_we_n) o_we++;
      if (mem_dq_oe) begin
        o_dqe++;
        if (mem_dq_out != v.d || mem_cs_n) o_bad++;
      end
      if (rsp_valid) begin
        o_rsp++;
        o_rsp_at = k;
        o_rd = rsp_rdata;
      end
    end
  endtask

  initial begin
    logic [15:0] exp_rd;
    int lows;
    n_chk = 0;
    n_fail = 0;
    req_valid = 1'b0;
    req_write = 1'b0;
    req_addr  = '0;
    req_wdata = '0;
    req_mask  = '0;
    for (int i = 0; i < 256; i++) begin
      sram[i]   = 16'h0000;
      shadow[i] = 16'h0000;
    end
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1: pins during reset
    chk("R1 reset pins", {mem_cs_n, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n, mem_dq_oe}, 6'b111110);
    chk("R1 reset rsp_valid", rsp_valid, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 idle after reset", {mem_cs_n, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n, mem_dq_oe, req_ready}, 7'b1111101);

    // Vector table
    for (int i = 0; i < 12; i++) begin
      run_op(VECS[i]);
      chk($sformatf("R8 ready low while busy v%0d", i), o_rdy, 0);
      chk($sformatf("R4 R6 pins match request v%0d", i), o_bad, 0);
      chk($sformatf("R1 idle at window end v%0d", i), {mem_cs_n, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n, mem_dq_oe}, 6'b111110);
      if (VECS[i].wr) begin
        chk($sformatf("R5 cs low cycles v%0d", i), o_cs, WR_E);
        chk($sformatf("R5 we low cycles v%0d", i), o_we, WP_E);
        chk($sformatf("R5 we high in first cycle v%0d", i), o_we_first, 1);
        chk($sformatf("R5 oe never low in write v%0d", i), o_oe, 0);
        chk($sformatf("R10 drive cycles v%0d", i), o_dqe, WR_E);
        chk($sformatf("R3 no rsp on write v%0d", i), o_rsp, 0);
        if (VECS[i].m[0]) shadow[VECS[i].a[7:0]][7:0]  = VECS[i].d[7:0];
        if (VECS[i].m[1]) shadow[VECS[i].a[7:0]][15:8] = VECS[i].d[15:8];
      end else begin
        exp_rd = shadow[VECS[i].a[7:0]] &
                 {{8{VECS[i].m[1]}}, {8{VECS[i].m[0]}}};
        chk($sformatf("R2 cs low cycles v%0d", i), o_cs, RD_E);
        chk($sformatf("R2 oe low cycles v%0d", i), o_oe, RD_E);
        chk($sformatf("R2 we stays high v%0d", i), o_we, 0);
        chk($sformatf("R10 no drive on read v%0d", i), o_dqe, 0);
        chk($sformatf("R3 one rsp strobe v%0d", i), o_rsp, 1);
        chk($sformatf("R3 rsp cycle v%0d", i), o_rsp_at, RD_E + 1);
        if (VECS[i].m == 2'b00)
          chk($sformatf("R9 empty mask reads zero v%0d", i), o_rd, exp_rd);
        else
          chk($sformatf("R4 read data v%0d", i), o_rd, exp_rd);
      end
    end
    chk("R9 empty-mask write left word unchanged", sram[8'h10], 16'hFF34);

    // R7: turnaround after a read
    run_op('{1'b0, 16'h0021, 16'h0000, 2'b11});
    req_valid = 1'b0;
    @(negedge clk);
    req_valid = 1'b1;
    req_write = 1'b0;
    req_addr  = 16'h0021;
    req_mask  = 2'b11;
    #1;
    chk("R7 read right after read", req_ready, 1);
    req_valid = 1'b0;
    // issue a fresh read, then a write the cycle its data returns
    @(negedge clk);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    lows = 0;
    while (!rsp_valid && lows < 50) begin
      @(negedge clk);
      lows++;
    end
    req_valid = 1'b1;
    req_write = 1'b1;
    req_wdata = 16'hC3C3;
    lows = 0;
    #1;
    while (!req_ready && lows < 50) begin
      lows++;
      @(negedge clk);
      #1;
    end
    chk("R7 write held off after read", lows, TA_E);
    @(negedge clk);
    req_valid = 1'b0;
    repeat (WR_E + 2) @(negedge clk);
    shadow[8'h21] = 16'hC3C3;
    run_op('{1'b0, 16'h0021, 16'h0000, 2'b11});
    chk("R7 write after turnaround landed", o_rd, 16'hC3C3);

    // R1: reset in the middle of a write
    @(negedge clk);
    req_valid = 1'b1;
    req_write = 1'b1;
    req_addr  = 16'h0040;
    req_wdata = 16'h9999;
    req_mask  = 2'b11;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk("R5 write pulse active before reset", mem_we_n, 0);
    rst_n = 1'b0;
    #1;
    chk("R1 async reset mid-write", {mem_cs_n, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n, mem_dq_oe}, 6'b111110);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 ready after mid-write reset", req_ready, 1);

    report();
    $finish;
  end

endmodule